// File: doc/BRIEF.md
# Victim Line Buffer

A small fully associative store that sits beside a direct-mapped cache and keeps the lines that cache has recently thrown out. Each entry holds a valid flag, the full line address (tag and set bits together) and the line data. The main cache presents every evicted line on the insert port. It also presents every lookup address on the lookup port in the same cycle it probes its own tag array. The answer is combinational, so a hit here costs no more than a hit in the main cache.

When a lookup hits and the main cache displaces a line in the same cycle, the two lines are exchanged. The hit line goes back to the main cache on the lookup data output. The displaced line is written into the slot that hit and becomes the most recently used entry. A hit with no displaced line removes the entry from the buffer, so each line lives in only one of the two structures. Recency among entries is kept with a small age counter per entry. An insert into a full buffer overwrites the oldest entry. The entry count, address width and line width are parameters.

Top module: `victim_buffer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the buffer holds no lines. Every lookup made before the first insert misses.
- R2: A lookup with lookupValid high raises lookupHit in the same cycle when the address is held, and puts that entry's data on lookupData. A lookup of an address that is not held gives lookupHit 0 and lookupData all zeros.
- R3: An insert (insertValid high, with no lookup hit in that cycle) stores the line when its address is not already present. The line can then be found by later lookups.
- R4: An insert whose address is already held replaces that entry's data in place and makes it the most recently used. No second copy is created and no other entry is lost.
- R5: An insert of a new address into a full buffer replaces the least recently used entry. Recency counts inserts, in-place updates and swap writes, and the newest of these is the most recently used.
- R6: When a lookup hits and insertValid is high in the same cycle, lookupData returns the old line. The insert line then takes that entry's slot as the most recently used entry, and the looked-up address is no longer held.
- R7: A lookup hit with insertValid low removes the hit entry. The recency order of the remaining entries is unchanged, and the freed slot is reused before any entry is evicted.
- R8: With lookupValid low, lookupHit is 0 and lookupData is zero, and the buffer contents do not change. With insertValid low, the insert address and data have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupAddr | input | ADDR_W | Line address searched |
| lookupHit | output | 1 | Lookup found the address (combinational) |
| lookupData | output | DATA_W | Line data of the hit entry, zero on a miss |
| insertValid | input | 1 | The main cache evicts a line this cycle |
| insertAddr | input | ADDR_W | Line address of the evicted line |
| insertData | input | DATA_W | Data of the evicted line |

## Verification
The bench fills the buffer past capacity after re-inserting one address. A design that counted the re-insert as a new line, or aged entries on the wrong event, would evict the wrong address and lose a line that is still live. Swaps are checked on both sides: the old data must appear in the swap cycle and the new line must sit in the same slot afterwards. A design that wrote the displaced line to a free or oldest slot would push out an innocent entry. A hit with no displaced line must free its slot, so that the next new line uses that slot and evicts nothing. A long mixed run over a small address range then exercises duplicate inserts, swaps onto the same address and lookups of absent lines, against a recency-ordered reference model.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;

  // Strobes from the control to the storage for the slot chosen this cycle.
  typedef struct packed {
    logic wrEn;   // write address and data into the slot, mark valid
    logic clrEn;  // invalidate the slot
  } vbuf_strobe_t;

  // Effect of this cycle on the recency order.
  typedef enum logic [1:0] {
    TOUCH_NONE,
    TOUCH_NEW,   // a free slot becomes the most recent entry
    TOUCH_OLD,   // a held slot is rewritten and becomes the most recent entry
    TOUCH_DROP   // a held slot leaves the order
  } vbuf_touch_t;

endpackage

// File: rtl/vbuf_datapath.sv
module vbuf_datapath
  import vbuf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  vbuf_strobe_t       strobe,
  input  logic [IDX_W-1:0]   slotIdx,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  lookupAddr,
  output logic               lookupMatch,
  output logic [IDX_W-1:0]   lookupIdx,
  output logic [DATA_W-1:0]  lineData,
  output logic               insMatch,
  output logic [IDX_W-1:0]   insMatchIdx,
  output logic               freeAvail,
  output logic [IDX_W-1:0]   freeIdx,
  output logic [ENTRIES-1:0] validVec
);

  logic [ADDR_W-1:0] addrQ [ENTRIES];
  logic [DATA_W-1:0] dataQ [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] insVec;

  // One comparator pair per entry, all searched at once.
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gCompare
      assign matchVec[g] = validVec[g] && (addrQ[g] == lookupAddr);
      assign insVec[g]   = validVec[g] && (addrQ[g] == wrAddr);
    end
  endgenerate

  always_comb begin
    lookupIdx   = '0;
    insMatchIdx = '0;
    freeIdx     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) lookupIdx   = IDX_W'(i);
      if (insVec[i])   insMatchIdx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign lookupMatch = |matchVec;
  assign insMatch    = |insVec;
  assign freeAvail   = ~&validVec;
  assign lineData    = dataQ[lookupIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (strobe.wrEn) begin
      validVec[slotIdx] <= 1'b1;
    end else if (strobe.clrEn) begin
      validVec[slotIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      addrQ[slotIdx] <= wrAddr;
      dataQ[slotIdx] <= wrData;
    end
  end

  // R1: reset leaves no entry valid in the following cycle.
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rstN |=> (validVec == '0));

  // R4: an address is never held twice, so at most one entry matches.
  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(matchVec) <= 1);

endmodule

// File: rtl/vbuf_ctrl.sv
module vbuf_ctrl
  import vbuf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               lookupMatch,
  input  logic [IDX_W-1:0]   lookupIdx,
  input  logic               insertValid,
  input  logic               insMatch,
  input  logic [IDX_W-1:0]   insMatchIdx,
  input  logic               freeAvail,
  input  logic [IDX_W-1:0]   freeIdx,
  input  logic [ENTRIES-1:0] validVec,
  output vbuf_strobe_t       strobe,
  output logic [IDX_W-1:0]   slotIdx,
  output logic               lookupHit
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // Age 0 is the most recent entry; valid entries hold distinct ages.
  logic [IDX_W-1:0] ageQ [ENTRIES];
  logic [IDX_W-1:0] lruIdx;
  logic [IDX_W-1:0] pivotAge;
  vbuf_touch_t      touch;

  assign lookupHit = lookupValid && lookupMatch;

  always_comb begin
    lruIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (validVec[i] && ageQ[i] == OLDEST) lruIdx = IDX_W'(i);
    end
  end

  // Slot choice: swap, then drop, then update, free slot, oldest entry.
  always_comb begin
    touch   = TOUCH_NONE;
    slotIdx = '0;
    if (lookupHit && insertValid) begin
      touch   = TOUCH_OLD;
      slotIdx = lookupIdx;
    end else if (lookupHit) begin
      touch   = TOUCH_DROP;
      slotIdx = lookupIdx;
    end else if (insertValid) begin
      if (insMatch) begin
        touch   = TOUCH_OLD;
        slotIdx = insMatchIdx;
      end else if (freeAvail) begin
        touch   = TOUCH_NEW;
        slotIdx = freeIdx;
      end else begin
        touch   = TOUCH_OLD;
        slotIdx = lruIdx;
      end
    end
  end

  assign strobe.wrEn  = (touch == TOUCH_NEW) || (touch == TOUCH_OLD);
  assign strobe.clrEn = (touch == TOUCH_DROP);
  assign pivotAge     = ageQ[slotIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < ENTRIES; j++) ageQ[j] <= '0;
    end else if (touch != TOUCH_NONE) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (IDX_W'(j) == slotIdx) begin
          ageQ[j] <= '0;
        end else if (validVec[j]) begin
          case (touch)
            TOUCH_NEW:  ageQ[j] <= ageQ[j] + 1'b1;
            TOUCH_OLD:  if (ageQ[j] < pivotAge) ageQ[j] <= ageQ[j] + 1'b1;
            TOUCH_DROP: if (ageQ[j] > pivotAge) ageQ[j] <= ageQ[j] - 1'b1;
            default:    ;
          endcase
        end
      end
    end
  end

  // R5: ages of held entries stay below the occupancy, so the oldest
  // entry of a full buffer always carries the top age.
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gAgeCheck
      assert_age_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
        validVec[g] |-> (int'(ageQ[g]) < $countones(validVec)));
    end
  endgenerate

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import vbuf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupHit,
  output logic [DATA_W-1:0] lookupData,
  input  logic              insertValid,
  input  logic [ADDR_W-1:0] insertAddr,
  input  logic [DATA_W-1:0] insertData
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  vbuf_strobe_t       strobe;
  logic [IDX_W-1:0]   slotIdx;
  logic               lookupMatch;
  logic [IDX_W-1:0]   lookupIdx;
  logic [DATA_W-1:0]  lineData;
  logic               insMatch;
  logic [IDX_W-1:0]   insMatchIdx;
  logic               freeAvail;
  logic [IDX_W-1:0]   freeIdx;
  logic [ENTRIES-1:0] validVec;

  vbuf_datapath #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx),
    .wrAddr(insertAddr), .wrData(insertData), .lookupAddr(lookupAddr),
    .lookupMatch(lookupMatch), .lookupIdx(lookupIdx), .lineData(lineData),
    .insMatch(insMatch), .insMatchIdx(insMatchIdx),
    .freeAvail(freeAvail), .freeIdx(freeIdx), .validVec(validVec)
  );

  vbuf_ctrl #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid),
    .lookupMatch(lookupMatch), .lookupIdx(lookupIdx),
    .insertValid(insertValid), .insMatch(insMatch), .insMatchIdx(insMatchIdx),
    .freeAvail(freeAvail), .freeIdx(freeIdx), .validVec(validVec),
    .strobe(strobe), .slotIdx(slotIdx), .lookupHit(lookupHit)
  );

  assign lookupData = lookupHit ? lineData : '0;

  // R6: after a swap, the displaced line is found with its own data.
  assert_swap_lands_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lookupHit && insertValid) |=>
      (!(lookupValid && lookupAddr == $past(insertAddr)) ||
       (lookupHit && lookupData == $past(insertData))));

  // R7: a hit with nothing displaced leaves the buffer.
  assert_drop_on_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lookupHit && !insertValid) |=>
      !(lookupValid && lookupAddr == $past(lookupAddr) && lookupHit));

endmodule

// File: tb/victim_buffer_test.sv
module victim_buffer_test;
  localparam int N  = 4;
  localparam int AW = 26;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lookupValid = 1'b0;
  logic [AW-1:0] lookupAddr = '0;
  logic          lookupHit;
  logic [DW-1:0] lookupData;
  logic          insertValid = 1'b0;
  logic [AW-1:0] insertAddr = '0;
  logic [DW-1:0] insertData = '0;

  always #10 clk = ~clk;

  victim_buffer #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .lookupHit(lookupHit), .lookupData(lookupData), .insertValid(insertValid),
    .insertAddr(insertAddr), .insertData(insertData)
  );

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } line_t;
  line_t model[$];   // front is the most recent line
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic int findLine(logic [AW-1:0] a);
    for (int i = 0; i < model.size(); i++) if (model[i].a == a) return i;
    return -1;
  endfunction

  task automatic step(bit lv, logic [AW-1:0] la, bit iv, logic [AW-1:0] ia,
                      logic [DW-1:0] id, string req);
    int k;
    int m;
    bit expHit;
    logic [DW-1:0] expData;
    line_t e;
    @(negedge clk);
    lookupValid = lv; lookupAddr = la;
    insertValid = iv; insertAddr = ia; insertData = id;
    #2;
    k = findLine(la);
    expHit = lv && (k >= 0);
    expData = expHit ? model[k].d : '0;
    checks++;
    if (lookupHit !== expHit || lookupData !== expData) begin
      errors++;
      $display("FAIL %s: addr %h hit %b data %h, expected hit %b data %h",
               req, la, lookupHit, lookupData, expHit, expData);
    end
    @(posedge clk);
    e.a = ia; e.d = id;
    if (expHit && iv) begin
      model.delete(k);
      model.push_front(e);
    end else if (expHit) begin
      model.delete(k);
    end else if (iv) begin
      m = findLine(ia);
      if (m >= 0) model.delete(m);
      else if (model.size() == N) void'(model.pop_back());
      model.push_front(e);
    end
  endtask

  task automatic look(logic [AW-1:0] a, string req);
    step(1'b1, a, 1'b0, '0, '0, req);
  endtask

  task automatic put(logic [AW-1:0] a, logic [DW-1:0] d, string req);
    step(1'b0, '0, 1'b1, a, d, req);
  endtask

  localparam logic [AW-1:0] LA = 26'h00A1, LB = 26'h00B2, LC = 26'h00C3,
                            LD = 26'h00D4, LE = 26'h00E5, LF = 26'h00F6,
                            LG = 26'h0107, LH = 26'h0218, LX = 26'h3FF0;

  initial begin
    repeat (3) @(posedge clk);
    look(LA, "R1 empty after reset");
    @(negedge clk);
    rstN = 1'b1;
    look(LA, "R1 empty after release");
    look(LX, "R1 empty after release");

    put(LA, 64'hAAAA_0001, "R3 insert");
    put(LB, 64'hBBBB_0001, "R3 insert");
    put(LC, 64'hCCCC_0001, "R3 insert");
    put(LD, 64'hDDDD_0001, "R3 insert");
    // Non-destructive probes: lookup hit with the same line reinserted.
    step(1'b1, LA, 1'b1, LA, 64'hAAAA_0001, "R2 hit data");
    step(1'b1, LX, 1'b0, '0, '0, "R2 absent miss");
    step(1'b1, 26'h0001, 1'b0, '0, '0, "R2 absent miss");

    put(LB, 64'hBBBB_0002, "R4 update in place");
    step(1'b1, LB, 1'b1, LB, 64'hBBBB_0002, "R4 new data");
    step(1'b1, LC, 1'b1, LC, 64'hCCCC_0001, "R4 no loss");
    step(1'b1, LD, 1'b1, LD, 64'hDDDD_0001, "R4 no loss");
    // Order now: D C B A; E must evict A.
    put(LE, 64'hEEEE_0001, "R5 full insert");
    look(LA, "R5 oldest evicted");
    step(1'b1, LB, 1'b1, LB, 64'hBBBB_0002, "R5 survivor");

    // Swap: C returned, F takes its slot.
    step(1'b1, LC, 1'b1, LF, 64'hFFFF_0001, "R6 swap returns old line");
    look(LC, "R6 swapped line gone");
    step(1'b1, LF, 1'b1, LF, 64'hFFFF_0001, "R6 displaced line held");
    // Order: F B E D; G evicts D.
    put(LG, 64'h6666_0001, "R5 after swap");
    look(LD, "R5 evicted after swap");

    // Hit with no displaced line drops E.
    look(LE, "R7 hit removes line");
    look(LE, "R7 removed");
    put(LH, 64'h8888_0001, "R7 freed slot reused");
    step(1'b1, LF, 1'b1, LF, 64'hFFFF_0001, "R7 no eviction");
    step(1'b1, LB, 1'b1, LB, 64'hBBBB_0002, "R7 no eviction");
    step(1'b1, LG, 1'b1, LG, 64'h6666_0001, "R7 no eviction");

    step(1'b0, LH, 1'b0, LA, 64'h1234_5678, "R8 idle ports");
    step(1'b1, LH, 1'b1, LH, 64'h8888_0001, "R8 contents unchanged");
    look(LA, "R8 idle insert ignored");

    for (int n = 0; n < 600; n++) begin
      bit lv;
      bit iv;
      logic [AW-1:0] la;
      logic [AW-1:0] ia;
      lv = ($urandom % 4) != 0;
      iv = ($urandom % 2) != 0;
      la = AW'($urandom_range(0, 7));
      ia = AW'($urandom_range(0, 7));
      if (lv && iv && findLine(la) >= 0 && findLine(ia) >= 0) ia = la;
      step(lv, la, iv, ia, {$urandom, $urandom}, "R2 R3 R4 R5 R6 R7 mixed");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule